// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers up to eight interrupt request lines from peripherals and presents a single interrupt output to a processor core. A request is captured on a rising edge of its line and then stays pending. Each line has its own mask bit. Among the pending lines that are not masked, the lowest-numbered line wins.

The core collects an interrupt with two low pulses on an active-low acknowledge input. The first pulse takes the interrupt output low and freezes the winning line. The second pulse places that line's vector, which is its number plus a base of 32, on an 8-bit bus for one cycle. The same pulse moves the request from pending to in-service.

While a line is in service, only lines of strictly higher priority can raise the interrupt again. A small write port loads the mask register and issues end-of-interrupt commands.

Top module: `pic_top`

## Requirements
- R1: The vector for IRQ n is 32 + n. It is delivered on `vec_out` in the cycle that `vec_valid` is high.
- R2: A request is latched only on a rising edge of its line (low in one clock, high in the next). A line held high latches once.
- R3: At the first falling edge of `ack_n`, `int_out` goes low in the next cycle. The winner is frozen at that edge.
- R4: At the second falling edge of `ack_n`, `vec_valid` is high for exactly one cycle, in the next cycle.
- R5: A line whose mask bit is 1 never causes `int_out`. Its latched request is kept, so clearing the mask bit later raises `int_out`.
- R6: A latched request stays pending until the second acknowledge pulse that delivers it.
- R7: Priority is fixed: IRQ0 is highest and IRQ7 is lowest.
- R8: The second acknowledge pulse clears the delivered line's pending bit and sets its in-service bit.
- R9: While any in-service bit is set, `int_out` is raised only for unmasked pending lines with a lower index than the lowest-indexed in-service line.
- R10: A write with `wr_cmd`=1 (end of interrupt) clears the lowest-indexed in-service bit. A write with `wr_cmd`=0 loads the mask from `wr_data`, where bit n masks IRQ n.
- R11: If no line is eligible at the first pulse, the second pulse returns the spurious vector 39 (32 + 7) and changes no pending or in-service bit.
- R12: After reset `int_out` and `vec_valid` are 0, the mask is all zeros (all lines enabled), and nothing is pending or in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 8 | Request lines, edge sensitive |
| ack_n | input | 1 | Active-low acknowledge from the core |
| wr_en | input | 1 | Register write strobe |
| wr_cmd | input | 1 | 0: load mask, 1: end of interrupt |
| wr_data | input | 8 | Mask value for mask writes |
| int_out | output | 1 | Interrupt request to the core |
| vec_out | output | 8 | Vector bus |
| vec_valid | output | 1 | One-cycle strobe marking `vec_out` |

## Verification
The assertions assume that `irq_in` and `ack_n` are synchronous to `clk`. They also assume that the core pairs its acknowledge pulses and does not write the mask or issue an end of interrupt between the two pulses of one sequence.

The bench drives every input on the falling clock edge. Each acknowledge is issued as a complete two-pulse task, and each request as a one-cycle-high pulse or a deliberate long hold. This keeps the stimulus inside those assumptions, while random picks of line, mask value and operation order vary the competing requests.

// File: rtl/pic_pkg.sv
// Shared types for the priority interrupt controller.
// Assumes nothing beyond a common clock domain for all users.
package pic_pkg;
    typedef enum logic {
        ACK_IDLE  = 1'b0,
        ACK_WAIT2 = 1'b1
    } ack_state_t;
endpackage

// File: rtl/pic_req_latch.sv
// Captures a rising edge on each request line into a pending bit.
// A pending bit stays set until its clear pulse arrives.
// Assumes the lines are synchronous to clk.
module pic_req_latch #(
    parameter int N_IRQ = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq_in,
    input  logic [N_IRQ-1:0] clr,
    output logic [N_IRQ-1:0] pend
);
    logic [N_IRQ-1:0] irq_q;

    for (genvar g = 0; g < N_IRQ; g++) begin : g_line
        // One edge detector and pending flop per line; a new edge wins over a clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                irq_q[g] <= 1'b0;
                pend[g]  <= 1'b0;
            end else begin
                irq_q[g] <= irq_in[g];
                pend[g]  <= (pend[g] & ~clr[g]) | (irq_in[g] & ~irq_q[g]);
            end
        end
    end

    // R6: a pending bit only drops when its clear was requested.
    p_pend_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(pend) & ~$past(clr)) & ~pend) == '0));
endmodule

// File: rtl/pic_resolver.sv
// Picks the winning request: unmasked, pending, above every in-service
// line, lowest index first. Purely combinational.
module pic_resolver #(
    parameter int N_IRQ = 8,
    localparam int IW   = $clog2(N_IRQ)
) (
    input  logic [N_IRQ-1:0] pend,
    input  logic [N_IRQ-1:0] mask,
    input  logic [N_IRQ-1:0] isr,
    output logic [IW-1:0]    win_idx,
    output logic             win_ok
);
    logic [N_IRQ-1:0] blocked;
    logic [N_IRQ-1:0] cand;

    // blocked[i] is set when line i or any higher-priority line is in service.
    assign blocked[0] = isr[0];
    for (genvar g = 1; g < N_IRQ; g++) begin : g_block
        assign blocked[g] = blocked[g-1] | isr[g];
    end

    assign cand = pend & ~mask & ~blocked;

    // Fixed priority: scan from lowest priority up so the lowest index wins.
    always_comb begin
        win_idx = '0;
        for (int i = N_IRQ - 1; i >= 0; i--) begin
            if (cand[i]) win_idx = IW'(i);
        end
    end

    assign win_ok = |cand;
endmodule

// File: rtl/pic_ack_seq.sv
// Runs the two-pulse acknowledge handshake.
// The first falling edge of ack_n freezes the winner; the second falling
// edge emits the vector for one cycle and pulses take_oh for the delivered line.
// Assumes the core pairs its pulses.
module pic_ack_seq
    import pic_pkg::*;
#(
    parameter int N_IRQ    = 8,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 32,
    localparam int IW      = $clog2(N_IRQ)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_n,
    input  logic [IW-1:0]    win_idx,
    input  logic             win_ok,
    output logic             idle,
    output logic [N_IRQ-1:0] take_oh,
    output logic [VEC_W-1:0] vec_out,
    output logic             vec_valid
);
    localparam logic [VEC_W-1:0] SPURIOUS = VEC_W'(VEC_BASE + N_IRQ - 1);

    ack_state_t    state;
    logic          ack_q;
    logic          fall;
    logic [IW-1:0] frz_idx;
    logic          frz_ok;

    assign fall = ack_q & ~ack_n;
    assign idle = (state == ACK_IDLE);

    // Pulse the delivered line's one-hot on the second falling edge.
    always_comb begin
        take_oh = '0;
        if (state == ACK_WAIT2 && fall && frz_ok) take_oh[frz_idx] = 1'b1;
    end

    // Sequence state, frozen winner and vector output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ACK_IDLE;
            ack_q     <= 1'b1;
            frz_idx   <= '0;
            frz_ok    <= 1'b0;
            vec_out   <= '0;
            vec_valid <= 1'b0;
        end else begin
            ack_q     <= ack_n;
            vec_valid <= 1'b0;
            if (fall) begin
                if (state == ACK_IDLE) begin
                    frz_idx <= win_idx;
                    frz_ok  <= win_ok;
                    state   <= ACK_WAIT2;
                end else begin
                    vec_out   <= frz_ok ? VEC_W'(VEC_BASE) + VEC_W'(frz_idx) : SPURIOUS;
                    vec_valid <= 1'b1;
                    state     <= ACK_IDLE;
                end
            end
        end
    end

    // R4: the vector strobe lasts one cycle.
    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);
    // R1: a delivered vector lies in the controller's vector range.
    p_vec_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (vec_out >= VEC_W'(VEC_BASE) && vec_out <= SPURIOUS));
    // R3: a first pulse always moves the sequence out of idle.
    p_first_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && fall) |=> !idle);
endmodule

// File: rtl/pic_top.sv
// Vectored priority interrupt controller, top level.
// Holds the mask and in-service registers, decodes the write port and
// derives the interrupt output. Assumes synchronous inputs, and no register
// writes between the two pulses of one acknowledge.
module pic_top #(
    parameter int N_IRQ    = 8,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq_in,
    input  logic             ack_n,
    input  logic             wr_en,
    input  logic             wr_cmd,
    input  logic [N_IRQ-1:0] wr_data,
    output logic             int_out,
    output logic [VEC_W-1:0] vec_out,
    output logic             vec_valid
);
    localparam int IW = $clog2(N_IRQ);

    logic [N_IRQ-1:0] pend;
    logic [N_IRQ-1:0] mask;
    logic [N_IRQ-1:0] isr;
    logic [N_IRQ-1:0] take_oh;
    logic [IW-1:0]    win_idx;
    logic             win_ok;
    logic             idle;

    pic_req_latch #(.N_IRQ(N_IRQ)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_in (irq_in),
        .clr    (take_oh),
        .pend   (pend)
    );

    pic_resolver #(.N_IRQ(N_IRQ)) u_res (
        .pend    (pend),
        .mask    (mask),
        .isr     (isr),
        .win_idx (win_idx),
        .win_ok  (win_ok)
    );

    pic_ack_seq #(.N_IRQ(N_IRQ), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_n     (ack_n),
        .win_idx   (win_idx),
        .win_ok    (win_ok),
        .idle      (idle),
        .take_oh   (take_oh),
        .vec_out   (vec_out),
        .vec_valid (vec_valid)
    );

    // Request the core only while no acknowledge is in progress.
    assign int_out = idle & win_ok;

    // Mask register loaded from the write port.
    always_ff @(posedge clk) begin
        if (!rst_n)                 mask <= '0;
        else if (wr_en && !wr_cmd)  mask <= wr_data;
    end

    // In-service tracking: set on delivery, lowest index cleared on end of interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) isr <= '0;
        else        isr <= ((wr_en && wr_cmd) ? (isr & (isr - 1'b1)) : isr) | take_oh;
    end

    // R5: the interrupt output implies an unmasked pending request.
    p_masked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> |(pend & ~mask));
    // R8: at most one in-service bit changes per cycle.
    p_isr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(isr ^ $past(isr)) <= 1));
endmodule

// File: tb/pic_top_tb.sv
module pic_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic       ack_n = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_cmd = 1'b0;
    logic [7:0] wr_data = '0;
    logic       int_out;
    logic [7:0] vec_out;
    logic       vec_valid;

    int n_tests = 0;
    int n_fail  = 0;

    // model state
    logic [7:0] m_pend = '0;
    logic [7:0] m_mask = '0;
    logic [7:0] m_isr  = '0;

    always #2.5 clk = ~clk;

    pic_top u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ack_n(ack_n),
        .wr_en(wr_en), .wr_cmd(wr_cmd), .wr_data(wr_data),
        .int_out(int_out), .vec_out(vec_out), .vec_valid(vec_valid)
    );

    function automatic int exp_win();
        logic [7:0] blk = '0;
        logic       seen = 1'b0;
        for (int i = 0; i < 8; i++) begin
            seen = seen | m_isr[i];
            blk[i] = seen;
        end
        for (int i = 0; i < 8; i++)
            if (m_pend[i] && !m_mask[i] && !blk[i]) return i;
        return -1;
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_int(string req);
        check(req, {7'd0, int_out}, {7'd0, exp_win() >= 0});
    endtask

    task automatic pulse_irq(int n);
        irq_in[n] = 1'b1;
        @(negedge clk);
        irq_in[n] = 1'b0;
        @(negedge clk);
        m_pend[n] = 1'b1;
    endtask

    task automatic do_ack(string req);
        int w;
        w = exp_win();
        ack_n = 1'b0;
        @(negedge clk);
        check("R3 int drops after first pulse", {7'd0, int_out}, 8'd0);
        ack_n = 1'b1;
        @(negedge clk);
        ack_n = 1'b0;
        @(negedge clk);
        check({req, " valid"}, {7'd0, vec_valid}, 8'd1);
        check({req, " vector"}, vec_out, (w >= 0) ? 8'(32 + w) : 8'd39);
        ack_n = 1'b1;
        @(negedge clk);
        check("R4 valid one cycle", {7'd0, vec_valid}, 8'd0);
        if (w >= 0) begin
            m_pend[w] = 1'b0;
            m_isr[w]  = 1'b1;
        end
    endtask

    task automatic write_reg(logic cmd, logic [7:0] d);
        wr_en = 1'b1; wr_cmd = cmd; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (cmd) m_isr = m_isr & (m_isr - 8'd1);
        else     m_mask = d;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12 int_out after reset", {7'd0, int_out}, 8'd0);
        check("R12 vec_valid after reset", {7'd0, vec_valid}, 8'd0);

        // R5 masked line quiet, request kept
        write_reg(1'b0, 8'h10);
        pulse_irq(4);
        check("R5 masked line no int", {7'd0, int_out}, 8'd0);
        write_reg(1'b0, 8'h00);
        check("R5 unmask raises int", {7'd0, int_out}, 8'd1);
        do_ack("R1 vector irq4");
        write_reg(1'b1, 8'h00);

        // R7 priority
        pulse_irq(5);
        pulse_irq(2);
        do_ack("R7 irq2 beats irq5");
        // R9 lower line blocked by in-service
        check("R9 irq5 blocked by isr2", {7'd0, int_out}, 8'd0);
        pulse_irq(1);
        check("R9 irq1 preempts isr2", {7'd0, int_out}, 8'd1);
        do_ack("R8 nested irq1");
        write_reg(1'b1, 8'h00);
        check("R10 eoi clears isr1 only", {7'd0, int_out}, 8'd0);
        write_reg(1'b1, 8'h00);
        check("R10 eoi clears isr2", {7'd0, int_out}, 8'd1);
        do_ack("R6 irq5 still pending");
        write_reg(1'b1, 8'h00);

        // R11 spurious
        check("R11 idle before spurious", {7'd0, int_out}, 8'd0);
        do_ack("R11 spurious");
        check("R11 no state change", {7'd0, int_out}, 8'd0);

        // R2 held line latches once
        irq_in[3] = 1'b1;
        @(negedge clk); @(negedge clk);
        m_pend[3] = 1'b1;
        check("R2 edge latched", {7'd0, int_out}, 8'd1);
        do_ack("R2 irq3 vector");
        write_reg(1'b1, 8'h00);
        repeat (3) @(negedge clk);
        check("R2 held line no relatch", {7'd0, int_out}, 8'd0);
        irq_in[3] = 1'b0;
        @(negedge clk);

        // random mix
        for (int k = 0; k < 200; k++) begin
            int op;
            op = $urandom_range(0, 3);
            case (op)
                0: pulse_irq($urandom_range(0, 7));
                1: write_reg(1'b0, 8'($urandom & $urandom & $urandom));
                2: do_ack("R1 random ack");
                default: write_reg(1'b1, 8'h00);
            endcase
            check_int("R9 random int_out");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule